// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block caches virtual-to-physical page translations in a small array where any entry may hold any translation. Every entry carries a valid bit, the identifier of the address space that owns it, a virtual page number and a physical page number. A lookup compares the presented virtual page number, together with the identifier held in a current-space register, against all entries at once. One clock later it answers with a hit flag and the physical page number.

On a miss the block raises a walk request carrying the missing page and identifier. An external walker later returns the translation on the fill port, which writes it into the array. A context switch only reloads the current-space register. Translations of other address spaces stay resident and hit again once their space is current. A global flush and a per-identifier flush are provided.

The lookup port is valid/ready. Its only back-pressure is a pending walk request: while a walk request waits for its handshake, `lk_ready` is low. The response is a single-cycle pulse and cannot be stalled. The walk request is valid/ready, and its payload stays frozen until accepted. The fill port is valid/ready with `fill_ready` tied high, so every fill is taken in the cycle it is presented. Context switch and flush pins are plain strobes.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, the current identifier is 0, `rsp_valid` and `walk_req_valid` are low, and `lk_ready` and `fill_ready` are high.
- R2: A lookup is accepted in a cycle with `lk_valid` and `lk_ready` both high. In the next cycle `rsp_valid` pulses for one cycle. `rsp_hit` is 1 exactly when some valid entry has a matching virtual page and an identifier equal to the current-space register, and `rsp_ppn` then carries that entry's physical page.
- R3: An accepted lookup that misses raises `walk_req_valid` in the response cycle, with `walk_req_vpn` equal to the looked-up page and `walk_req_asid` equal to the current identifier at acceptance. The request and its payload hold until `walk_req_ready` is seen, and `lk_ready` stays low while it is pending.
- R4: A fill (`fill_valid`, always accepted) stores its page, identifier and physical page, so a later lookup of that page under that identifier hits with the filled physical page.
- R5: `ctx_we` loads `ctx_asid` into the current-space register and invalidates no entry. Translations of the previous space hit again after switching back.
- R6: A fill with no matching entry goes to the lowest-indexed invalid entry. If none is invalid, it replaces the entry named by a rotating pointer. The pointer starts at index 0 after reset and moves up by one, wrapping, after each such replacement.
- R7: A fill whose page and identifier match a valid entry overwrites that entry in place. It consumes no other entry, so at most one entry ever matches a given page and identifier.
- R8: `flush_all` clears every valid bit in one cycle.
- R9: `flush_asid_en` clears exactly the valid entries tagged with `flush_asid` and leaves all others.
- R10: A lookup accepted in the same cycle as a fill, flush or context switch is answered from the state before that cycle's update, including the old current identifier.
- R11: When a fill and a flush fall in the same cycle, the flush takes effect first and the filled entry ends up valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup can be accepted (no walk pending) |
| lk_vpn | input | VPN_W | Virtual page to translate |
| rsp_valid | output | 1 | Lookup answer pulse |
| rsp_hit | output | 1 | Translation found |
| rsp_ppn | output | PPN_W | Physical page on a hit, zero otherwise |
| walk_req_valid | output | 1 | Walk request pending |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_req_vpn | output | VPN_W | Page that missed |
| walk_req_asid | output | ASID_W | Identifier of the missing lookup |
| fill_valid | input | 1 | Translation returned by the walker |
| fill_ready | output | 1 | Always high |
| fill_vpn | input | VPN_W | Filled virtual page |
| fill_asid | input | ASID_W | Filled identifier |
| fill_ppn | input | PPN_W | Filled physical page |
| ctx_we | input | 1 | Load a new current identifier |
| ctx_asid | input | ASID_W | New current identifier |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_en | input | 1 | Invalidate entries of one identifier |
| flush_asid | input | ASID_W | Identifier to invalidate |

## Verification
The collision that matters most is a lookup that lands in the same cycle as a fill of the very page it asks for. Flushes and context switches can also fall in that cycle. Directed steps present a lookup together with a fill of its own page and expect a miss, then a hit on the next lookup. They also combine a flush with a fill and expect the filled entry to survive. Random traffic over a narrow page and identifier space then mixes these events freely. Each response is compared with a bench model whose answer was computed from the state held before that cycle's updates.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Which rule chose the entry written by a fill.
  typedef enum logic [1:0] {
    VIC_MERGE  = 2'd0,  // page and identifier already present
    VIC_FREE   = 2'd1,  // lowest invalid entry
    VIC_ROTATE = 2'd2   // rotating replacement pointer
  } vic_kind_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_tab,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_tab,
  input  logic [VPN_W-1:0]               key_vpn,
  input  logic [ASID_W-1:0]              key_asid,
  output logic [ENTRIES-1:0]             hit
);
  // One comparator per entry, all evaluated at once.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = valid[g] && (vpn_tab[g] == key_vpn) && (asid_tab[g] == key_asid);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] dup,
  input  logic               take,
  output logic [IDX_W-1:0]   idx,
  output vic_kind_e          kind
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] dup_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_dup;
  logic             any_free;

  // Downward scan so the lowest index wins.
  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    any_dup  = 1'b0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (dup[i]) begin
        dup_idx = IDX_W'(i);
        any_dup = 1'b1;
      end
      if (!valid[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_dup) begin
      idx  = dup_idx;
      kind = VIC_MERGE;
    end else if (any_free) begin
      idx  = free_idx;
      kind = VIC_FREE;
    end else begin
      idx  = rr_q;
      kind = VIC_ROTATE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (take && kind == VIC_ROTATE) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic              walk_req_valid,
  input  logic              walk_req_ready,
  output logic [VPN_W-1:0]  walk_req_vpn,
  output logic [ASID_W-1:0] walk_req_asid,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              ctx_we,
  input  logic [ASID_W-1:0] ctx_asid,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [ASID_W-1:0]              cur_asid_q;

  logic [ENTRIES-1:0] lk_hit_vec;
  logic [ENTRIES-1:0] fill_dup_vec;
  logic [IDX_W-1:0]   fill_idx;
  vic_kind_e          fill_kind;
  logic [PPN_W-1:0]   lk_ppn;
  logic               lk_fire;

  assign fill_ready = 1'b1;
  assign lk_ready   = !walk_req_valid;
  assign lk_fire    = lk_valid && lk_ready;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .valid    (valid_q),
    .vpn_tab  (vpn_q),
    .asid_tab (asid_q),
    .key_vpn  (lk_vpn),
    .key_asid (cur_asid_q),
    .hit      (lk_hit_vec)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
    .valid    (valid_q),
    .vpn_tab  (vpn_q),
    .asid_tab (asid_q),
    .key_vpn  (fill_vpn),
    .key_asid (fill_asid),
    .hit      (fill_dup_vec)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (valid_q),
    .dup   (fill_dup_vec),
    .take  (fill_valid),
    .idx   (fill_idx),
    .kind  (fill_kind)
  );

  // At most one entry matches, so an OR of masked pages selects it.
  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit_vec[i]) lk_ppn = lk_ppn | ppn_q[i];
    end
  end

  // Valid bits: flush first, fill overrides the written entry.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_all || (flush_asid_en && asid_q[i] == flush_asid)) valid_q[i] <= 1'b0;
      end
      if (fill_valid) valid_q[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      vpn_q[fill_idx]  <= fill_vpn;
      asid_q[fill_idx] <= fill_asid;
      ppn_q[fill_idx]  <= fill_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cur_asid_q <= '0;
    else if (ctx_we) cur_asid_q <= ctx_asid;
  end

  // Response and walk request registers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_ppn        <= '0;
      walk_req_valid <= 1'b0;
      walk_req_vpn   <= '0;
      walk_req_asid  <= '0;
    end else begin
      rsp_valid <= lk_fire;
      if (lk_fire) begin
        rsp_hit <= |lk_hit_vec;
        rsp_ppn <= lk_ppn;
      end
      if (walk_req_valid && walk_req_ready) walk_req_valid <= 1'b0;
      if (lk_fire && !(|lk_hit_vec)) begin
        walk_req_valid <= 1'b1;
        walk_req_vpn   <= lk_vpn;
        walk_req_asid  <= cur_asid_q;
      end
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_ready,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               walk_req_valid,
  input logic               walk_req_ready,
  input logic [VPN_W-1:0]   walk_req_vpn,
  input logic [ASID_W-1:0]  walk_req_asid,
  input logic               fill_valid,
  input logic               ctx_we,
  input logic [ASID_W-1:0]  ctx_asid,
  input logic               flush_all,
  input logic               flush_asid_en,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ASID_W-1:0]  cur_asid_q,
  input logic [ENTRIES-1:0] lk_hit_vec,
  input logic [ENTRIES-1:0] fill_dup_vec
);
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !(lk_valid && lk_ready)) |=> !rsp_valid); // R2
  AST_MISS_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> walk_req_valid); // R3
  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_req_ready) |=>
      (walk_req_valid && $stable(walk_req_vpn) && $stable(walk_req_asid))); // R3
  AST_WALK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |-> !lk_ready); // R3
  AST_CTX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_we |=> (cur_asid_q == $past(ctx_asid))); // R5
  AST_CTX_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_we && !fill_valid && !flush_all && !flush_asid_en) |=> (valid_q == $past(valid_q))); // R5
  AST_LOOKUP_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec)); // R7
  AST_FILL_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> $onehot0(fill_dup_vec)); // R7
  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !fill_valid) |=> (valid_q == '0)); // R8
  AST_FLUSH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && fill_valid) |=> ($countones(valid_q) == 1)); // R11
endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .lk_valid       (lk_valid),
  .lk_ready       (lk_ready),
  .rsp_valid      (rsp_valid),
  .rsp_hit        (rsp_hit),
  .walk_req_valid (walk_req_valid),
  .walk_req_ready (walk_req_ready),
  .walk_req_vpn   (walk_req_vpn),
  .walk_req_asid  (walk_req_asid),
  .fill_valid     (fill_valid),
  .ctx_we         (ctx_we),
  .ctx_asid       (ctx_asid),
  .flush_all      (flush_all),
  .flush_asid_en  (flush_asid_en),
  .valid_q        (valid_q),
  .cur_asid_q     (cur_asid_q),
  .lk_hit_vec     (lk_hit_vec),
  .fill_dup_vec   (fill_dup_vec)
);

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
  localparam int E  = 8;
  localparam int VW = 4;
  localparam int PW = 8;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_ready;
  logic [VW-1:0] lk_vpn = '0;
  logic rsp_valid, rsp_hit;
  logic [PW-1:0] rsp_ppn;
  logic walk_req_valid, walk_req_ready = 1'b1;
  logic [VW-1:0] walk_req_vpn;
  logic [AW-1:0] walk_req_asid;
  logic fill_valid = 1'b0, fill_ready;
  logic [VW-1:0] fill_vpn = '0;
  logic [AW-1:0] fill_asid = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic ctx_we = 1'b0;
  logic [AW-1:0] ctx_asid = '0;
  logic flush_all = 1'b0, flush_asid_en = 1'b0;
  logic [AW-1:0] flush_asid = '0;

  always #5 clk = ~clk;

  asid_tlb #(.ENTRIES(E), .VPN_W(VW), .PPN_W(PW), .ASID_W(AW)) i_asid_tlb (.*);

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  always @(posedge clk) cycles <= cycles + 1;

  // Reference model
  bit          m_v    [E];
  bit [VW-1:0] m_vpn  [E];
  bit [AW-1:0] m_asid [E];
  bit [PW-1:0] m_ppn  [E];
  int          m_rr   = 0;
  bit [AW-1:0] m_cur  = '0;

  // Drive fields for the next tick
  bit          d_lk, d_fill, d_ctx, d_fa, d_fae, d_wr;
  bit [VW-1:0] d_lvpn, d_fvpn;
  bit [AW-1:0] d_fasid, d_casid, d_faid;
  bit [PW-1:0] d_fppn;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit m_lookup(input bit [VW-1:0] vpn, input bit [AW-1:0] asid,
                                  output bit [PW-1:0] ppn);
    ppn = '0;
    for (int i = 0; i < E; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) begin
        ppn = m_ppn[i];
        return 1'b1;
      end
    return 1'b0;
  endfunction

  function automatic void m_update();
    int idx = -1;
    if (d_fill) begin
      for (int i = 0; i < E; i++)
        if (idx < 0 && m_v[i] && m_vpn[i] == d_fvpn && m_asid[i] == d_fasid) idx = i;
      for (int i = 0; i < E; i++)
        if (idx < 0 && !m_v[i]) idx = i;
      if (idx < 0) begin
        idx  = m_rr;
        m_rr = (m_rr + 1) % E;
      end
    end
    for (int i = 0; i < E; i++)
      if (d_fa || (d_fae && m_asid[i] == d_faid)) m_v[i] = 1'b0;
    if (d_fill) begin
      m_v[idx] = 1'b1; m_vpn[idx] = d_fvpn; m_asid[idx] = d_fasid; m_ppn[idx] = d_fppn;
    end
    if (d_ctx) m_cur = d_casid;
  endfunction

  function automatic void clear_drive();
    d_lk = 0; d_fill = 0; d_ctx = 0; d_fa = 0; d_fae = 0; d_wr = 1;
  endfunction

  bit          last_acc;
  bit          last_hit;
  bit [PW-1:0] last_ppn;

  // Called at a falling edge: drive, advance one clock, check the answer.
  task automatic tick(input string tag);
    bit          acc;
    bit          eh;
    bit [PW-1:0] ep;
    bit [AW-1:0] ea;
    acc = d_lk && lk_ready;
    ea  = m_cur;
    eh  = m_lookup(d_lvpn, m_cur, ep);
    lk_valid = acc; lk_vpn = d_lvpn;
    fill_valid = d_fill; fill_vpn = d_fvpn; fill_asid = d_fasid; fill_ppn = d_fppn;
    ctx_we = d_ctx; ctx_asid = d_casid;
    flush_all = d_fa; flush_asid_en = d_fae; flush_asid = d_faid;
    walk_req_ready = d_wr;
    m_update();
    @(negedge clk);
    lk_valid = 0; fill_valid = 0; ctx_we = 0; flush_all = 0; flush_asid_en = 0;
    last_acc = acc; last_hit = eh; last_ppn = ep;
    check(rsp_valid == acc, {tag, " R2 rsp_valid"}, rsp_valid, acc);
    if (acc) begin
      check(rsp_hit == eh, {tag, " R2 hit"}, rsp_hit, eh);
      if (eh) check(rsp_ppn == ep, {tag, " R2 ppn"}, rsp_ppn, ep);
      else begin
        check(walk_req_valid && walk_req_vpn == d_lvpn && walk_req_asid == ea,
              {tag, " R3 walk request"}, {walk_req_valid, walk_req_vpn, walk_req_asid},
              {1'b1, d_lvpn, ea});
      end
    end
  endtask

  task automatic idle();
    clear_drive();
    tick("idle");
  endtask

  task automatic look(input bit [VW-1:0] vpn, input bit eh, input bit [PW-1:0] ep, input string tag);
    while (!lk_ready) idle();
    clear_drive();
    d_lk = 1; d_lvpn = vpn;
    tick(tag);
    check(rsp_hit == eh, {tag, " directed hit"}, rsp_hit, eh);
    if (eh) check(rsp_ppn == ep, {tag, " directed ppn"}, rsp_ppn, ep);
  endtask

  task automatic fill(input bit [VW-1:0] vpn, input bit [AW-1:0] asid, input bit [PW-1:0] ppn);
    clear_drive();
    d_fill = 1; d_fvpn = vpn; d_fasid = asid; d_fppn = ppn;
    tick("fill");
  endtask

  task automatic ctx(input bit [AW-1:0] a);
    clear_drive();
    d_ctx = 1; d_casid = a;
    tick("ctx");
  endtask

  task automatic flush_every();
    clear_drive();
    d_fa = 1;
    tick("flush");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit [VW-1:0] hold_vpn;
    clear_drive();
    d_lvpn = '0; d_fvpn = '0; d_fasid = '0; d_casid = '0; d_faid = '0; d_fppn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!rsp_valid && !walk_req_valid && lk_ready && fill_ready, "R1 reset outputs",
          {rsp_valid, walk_req_valid, lk_ready, fill_ready}, 4'b0011);
    look(4'd1, 0, 0, "R1 empty after reset");

    // R4 fill then hit
    fill(4'd1, 2'd0, 8'h11);
    look(4'd1, 1, 8'h11, "R4 fill hit");

    // R3 hold while walker stalls
    look(4'd2, 0, 0, "R3 miss");
    hold_vpn = walk_req_vpn;
    clear_drive(); d_wr = 0; d_lk = 1; d_lvpn = 4'd5;
    tick("R3 stall");
    check(walk_req_valid && !lk_ready && walk_req_vpn == hold_vpn, "R3 held",
          {walk_req_valid, lk_ready, walk_req_vpn}, {1'b1, 1'b0, hold_vpn});
    clear_drive(); d_wr = 0;
    tick("R3 stall2");
    check(walk_req_valid && walk_req_vpn == 4'd2, "R3 held twice", walk_req_vpn, 4'd2);
    idle();
    check(!walk_req_valid && lk_ready, "R3 released", {walk_req_valid, lk_ready}, 2'b01);

    // R10 lookup with fill of same page in one cycle
    clear_drive(); d_lk = 1; d_lvpn = 4'd2; d_fill = 1; d_fvpn = 4'd2; d_fasid = 2'd0; d_fppn = 8'h22;
    tick("R10 same-cycle fill");
    check(rsp_valid && !rsp_hit, "R10 pre-fill miss", rsp_hit, 0);
    look(4'd2, 1, 8'h22, "R10 later hit");

    // R5 context switch
    ctx(2'd1);
    look(4'd1, 0, 0, "R5 other space misses");
    fill(4'd1, 2'd1, 8'h33);
    look(4'd1, 1, 8'h33, "R5 new space hit");
    // R10 lookup in the same cycle as a switch uses the old identifier
    clear_drive(); d_lk = 1; d_lvpn = 4'd1; d_ctx = 1; d_casid = 2'd0;
    tick("R10 same-cycle ctx");
    check(rsp_hit && rsp_ppn == 8'h33, "R10 old identifier", rsp_ppn, 8'h33);
    look(4'd1, 1, 8'h11, "R5 switch back hits");

    // R9 flush one identifier
    clear_drive(); d_fae = 1; d_faid = 2'd1;
    tick("R9 flush id");
    look(4'd1, 1, 8'h11, "R9 other id kept");
    ctx(2'd1);
    look(4'd1, 0, 0, "R9 flushed id gone");
    ctx(2'd0);

    // R8 flush all
    flush_every();
    look(4'd1, 0, 0, "R8 flushed");
    look(4'd2, 0, 0, "R8 flushed too");

    // R11 flush and fill together
    clear_drive(); d_fa = 1; d_fill = 1; d_fvpn = 4'd7; d_fasid = 2'd0; d_fppn = 8'h77;
    tick("R11 flush+fill");
    look(4'd7, 1, 8'h77, "R11 fill survives");
    flush_every();

    // R7 duplicate fill overwrites in place
    for (int i = 0; i < E; i++) fill(VW'(i), 2'd0, PW'(8'h40 + i));
    fill(4'd3, 2'd0, 8'h99);
    for (int i = 0; i < E; i++)
      look(VW'(i), 1, (i == 3) ? 8'h99 : PW'(8'h40 + i), "R7 all resident");

    // R6 rotating replacement from index 0
    fill(4'd8, 2'd0, 8'h88);
    look(4'd0, 0, 0, "R6 slot0 evicted");
    look(4'd8, 1, 8'h88, "R6 new entry");
    look(4'd1, 1, 8'h41, "R6 slot1 still");
    fill(4'd9, 2'd0, 8'h89);
    look(4'd1, 0, 0, "R6 slot1 evicted");
    look(4'd2, 1, 8'h42, "R6 slot2 still");

    // Random traffic, checked by the model in every tick (R2 R3 R10)
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      clear_drive();
      d_lk    = ($urandom % 4) != 0;
      d_lvpn  = VW'($urandom);
      d_fill  = ($urandom % 3) == 0;
      d_fvpn  = VW'($urandom);
      d_fasid = AW'($urandom);
      d_fppn  = PW'($urandom);
      d_ctx   = ($urandom % 8) == 0;
      d_casid = AW'($urandom);
      d_fa    = ($urandom % 64) == 0;
      d_fae   = ($urandom % 32) == 0;
      d_faid  = AW'($urandom);
      d_wr    = ($urandom % 3) != 0;
      tick("random");
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule